// File: doc/BRIEF.md
# Inverse 4-point sine transform and reconstruction engine

This block rebuilds one 4x4 tile of 8-bit picture samples from a tile of signed 16-bit transform coefficients and a matching tile of 8-bit prediction samples. It runs a separable inverse sine-type transform in two one-dimensional passes. The first pass works down the columns of the coefficient tile. The second pass works along the rows of the intermediate tile. The block then adds the prediction and clamps each sample to the unsigned 8-bit range.

Tiles arrive as four row beats on a valid/ready input. Each beat carries four coefficients and the four prediction bytes of the same row. Once the fourth row is in, the block spends one cycle on the column pass and holds the intermediate tile in a register. It then emits the four reconstructed rows, top to bottom, on a valid/ready output. The row pass and the reconstruction are computed for each output row as it is presented. Input and output phases never overlap. A new tile is taken only after the last output row has been accepted.

Top module: `sine_recon4x4`

## Requirements
- R1: After reset, and whenever the block is collecting a tile, `in_ready` is 1 and `out_valid` is 0. `in_ready` and `out_valid` are never 1 in the same cycle.
- R2: A tile is exactly four accepted input beats: row 0 first, row 3 last. Lane j of a beat sits at bits [16j+15:16j] of `in_coef` and [8j+7:8j] of `in_pred`. After the clock edge that accepts row 3, `in_ready` and `out_valid` are both 0 for one cycle, and `out_valid` is 1 from the following edge.
- R3: Output rows appear in order 0,1,2,3, with lane j at bits [8j+7:8j] of `out_pix`. While `out_valid` is 1 and `out_ready` is 0, `out_pix` holds its value.
- R4: Each one-dimensional pass maps inputs s0..s3 to y0=29s0+74s1+84s2+55s3, y1=55s0+74s1-29s2-84s3, y2=74s0-74s2+74s3 and y3=84s0-74s1+55s2-29s3. Sums are formed at 32-bit signed precision.
- R5: The column pass takes rows 0..3 of a coefficient column as s0..s3. Output yk of column c becomes element (k,c) of the intermediate tile. It is rounded by adding 64, shifted arithmetically right by 7, and clamped to -32768..32767.
- R6: The row pass takes row i of the intermediate tile as s0..s3. Output yk becomes the residual at row i, column k. It is rounded by adding 2048, shifted arithmetically right by 12, and clamped to -32768..32767.
- R7: Each residual is added to the zero-extended prediction byte at the same position, modulo 2^16. The sum is read as signed and clamped to 0..255.
- R8: Input beats offered while the block is busy are ignored. After the edge that accepts output row 3, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input row beat offered |
| in_ready | output | 1 | Block accepts an input row |
| in_coef | input | 64 | Four signed 16-bit coefficients of one row |
| in_pred | input | 32 | Four prediction bytes of the same row |
| out_valid | output | 1 | Reconstructed row presented |
| out_ready | input | 1 | Consumer takes the presented row |
| out_pix | output | 32 | Four reconstructed bytes of one row |

## Verification
Two things can fall in the same cycle: the consumer taking the final output row, and a producer that is already pressing a new beat. The bench keeps `in_valid` high with junk data for the whole output phase, and it also stalls `out_ready` for two cycles on each row. Both junk and stalls are judged in the same way. The rows being drained must still match the integer model, and `in_ready` must rise exactly one edge after row 3 is taken. The next tile must also reconstruct correctly, which shows that none of the junk entered the coefficient store.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int LANES = 4;
  // sine-type kernel weights
  localparam int K_A = 29;
  localparam int K_B = 55;
  localparam int K_C = 74;
  localparam int K_D = 84;

  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_XFORM = 2'd1,
    ST_DRAIN = 2'd2
  } sr_state_e;
endpackage

// File: rtl/sr_kernel.sv
// One 4-point inverse sine-type pass with rounding shift and saturation.
module sr_kernel
  import sr_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int ACC_W = 32,
  parameter int SHIFT = 7
) (
  input  logic [LANES*IN_W-1:0]  s_in,
  output logic [LANES*OUT_W-1:0] o_out
);
  localparam logic signed [ACC_W-1:0] CA     = ACC_W'(K_A);
  localparam logic signed [ACC_W-1:0] CB     = ACC_W'(K_B);
  localparam logic signed [ACC_W-1:0] CC     = ACC_W'(K_C);
  localparam logic signed [ACC_W-1:0] CD     = ACC_W'(K_D);
  localparam logic signed [ACC_W-1:0] RND    = ACC_W'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

  logic signed [ACC_W-1:0] s   [LANES];
  logic signed [ACC_W-1:0] acc [LANES];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      s[i] = ACC_W'($signed(s_in[i*IN_W +: IN_W]));
    end
    acc[0] = CA * s[0] + CC * s[1] + CD * s[2] + CB * s[3];
    acc[1] = CB * s[0] + CC * s[1] - CA * s[2] - CD * s[3];
    acc[2] = CC * s[0] - CC * s[2] + CC * s[3];
    acc[3] = CD * s[0] - CC * s[1] + CB * s[2] - CA * s[3];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [ACC_W-1:0] shr;
    always_comb begin
      shr = (acc[k] + RND) >>> SHIFT;
      if (shr > SAT_HI) begin
        o_out[k*OUT_W +: OUT_W] = SAT_HI[OUT_W-1:0];
      end else if (shr < SAT_LO) begin
        o_out[k*OUT_W +: OUT_W] = SAT_LO[OUT_W-1:0];
      end else begin
        o_out[k*OUT_W +: OUT_W] = shr[OUT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sr_recon.sv
// Residual plus prediction with lane-width wrap, then unsigned clamp.
module sr_recon #(
  parameter int RES_W = 16,
  parameter int PIX_W = 8
) (
  input  logic [RES_W-1:0] res,
  input  logic [PIX_W-1:0] pred,
  output logic [PIX_W-1:0] pix
);
  localparam logic [RES_W-1:0] PIX_MAX = RES_W'((2 ** PIX_W) - 1);

  logic [RES_W-1:0] sum;

  always_comb begin
    sum = res + {{(RES_W - PIX_W){1'b0}}, pred};
    if (sum[RES_W-1]) begin
      pix = '0;
    end else if (sum > PIX_MAX) begin
      pix = '1;
    end else begin
      pix = sum[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/sine_recon4x4.sv
module sine_recon4x4
  import sr_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int PIX_W  = 8,
  parameter int ACC_W  = 32,
  parameter int SHIFT1 = 7,
  parameter int SHIFT2 = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*COEF_W-1:0] in_coef,
  input  logic [LANES*PIX_W-1:0]  in_pred,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*PIX_W-1:0]  out_pix
);
  localparam int ROW_CW = LANES * COEF_W;
  localparam int ROW_PW = LANES * PIX_W;
  localparam int CNT_W  = $clog2(LANES);
  localparam logic [CNT_W-1:0] LAST_ROW = CNT_W'(LANES - 1);

  sr_state_e        state_q, state_d;
  logic [CNT_W-1:0] row_q, row_d;
  logic             in_fire, out_fire, last_row;

  logic [ROW_CW-1:0] coef_q [LANES];
  logic [ROW_PW-1:0] pred_q [LANES];
  logic [ROW_CW-1:0] mid_q  [LANES];
  logic [ROW_CW-1:0] mid_d  [LANES];
  logic [ROW_CW-1:0] p1_out [LANES];
  logic [ROW_CW-1:0] res_row;

  assign in_ready  = (state_q == ST_FILL);
  assign out_valid = (state_q == ST_DRAIN);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign last_row  = (row_q == LAST_ROW);

  // control next state
  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    case (state_q)
      ST_FILL: begin
        if (in_fire) begin
          row_d = last_row ? '0 : row_q + 1'b1;
          if (last_row) state_d = ST_XFORM;
        end
      end
      ST_XFORM: state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (out_fire) begin
          row_d = last_row ? '0 : row_q + 1'b1;
          if (last_row) state_d = ST_FILL;
        end
      end
      default: state_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
    end
  end

  // tile storage, written by clock enable only
  always_ff @(posedge clk) begin
    for (int r = 0; r < LANES; r++) begin
      if (in_fire && (row_q == CNT_W'(r))) begin
        coef_q[r] <= in_coef;
        pred_q[r] <= in_pred;
      end
      if (state_q == ST_XFORM) begin
        mid_q[r] <= mid_d[r];
      end
    end
  end

  // column pass: one kernel per coefficient column
  for (genvar c = 0; c < LANES; c++) begin : g_col
    logic [ROW_CW-1:0] col_vec;
    always_comb begin
      for (int k = 0; k < LANES; k++) begin
        col_vec[k*COEF_W +: COEF_W] = coef_q[k][c*COEF_W +: COEF_W];
      end
    end
    sr_kernel #(
      .IN_W (COEF_W),
      .OUT_W(COEF_W),
      .ACC_W(ACC_W),
      .SHIFT(SHIFT1)
    ) u_col (
      .s_in (col_vec),
      .o_out(p1_out[c])
    );
  end

  // transpose: output k of column c lands at row k, lane c
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      for (int c = 0; c < LANES; c++) begin
        mid_d[k][c*COEF_W +: COEF_W] = p1_out[c][k*COEF_W +: COEF_W];
      end
    end
  end

  // row pass on the row being presented
  sr_kernel #(
    .IN_W (COEF_W),
    .OUT_W(COEF_W),
    .ACC_W(ACC_W),
    .SHIFT(SHIFT2)
  ) u_row (
    .s_in (mid_q[row_q]),
    .o_out(res_row)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_rec
    sr_recon #(
      .RES_W(COEF_W),
      .PIX_W(PIX_W)
    ) u_rec (
      .res (res_row[j*COEF_W +: COEF_W]),
      .pred(pred_q[row_q][j*PIX_W +: PIX_W]),
      .pix (out_pix[j*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/sine_recon4x4_chk.sv
module sine_recon4x4_chk #(
  parameter int N     = 4,
  parameter int ROW_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ROW_W-1:0] out_pix
);
  localparam int CW = $clog2(N);

  logic [CW-1:0] acc_cnt, out_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      out_cnt <= '0;
    end else begin
      if (in_valid && in_ready) begin
        acc_cnt <= (acc_cnt == CW'(N - 1)) ? '0 : acc_cnt + 1'b1;
      end
      if (out_valid && out_ready) begin
        out_cnt <= (out_cnt == CW'(N - 1)) ? '0 : out_cnt + 1'b1;
      end
    end
  end

  a_r1_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r2_fill_close: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && acc_cnt == CW'(N - 1))
      |=> (!in_ready && !out_valid) ##1 out_valid);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  a_r8_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_cnt == CW'(N - 1)) |=> (in_ready && !out_valid));
endmodule

bind sine_recon4x4 sine_recon4x4_chk #(
  .N    (sr_pkg::LANES),
  .ROW_W(ROW_PW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_pix  (out_pix)
);

// File: tb/test_sine_recon4x4.sv
`timescale 1ns/1ps
module test_sine_recon4x4;
  localparam int NB    = 6;
  localparam int NRAND = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [63:0] in_coef;
  logic [31:0] in_pred, out_pix;

  always #2.5 clk = ~clk;

  sine_recon4x4 i_sine_recon4x4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_pred(in_pred), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  int vectors = 0;
  int miscompares = 0;
  int m_c [4][4];
  int m_p [4][4];
  int m_o [4][4];

  // stimulus table: coefficient tiles in row-major order plus a prediction mode
  localparam logic [15:0] T_COEF [NB][16] = '{
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
      16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    '{16'h0040, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
      16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    '{16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF,
      16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF},
    '{16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000,
      16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000},
    '{16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000, 16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF,
      16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000, 16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF},
    '{16'h0123, 16'hFF10, 16'h0007, 16'hFFFF, 16'h0200, 16'hFE00, 16'h0033, 16'h0001,
      16'hFFC0, 16'h0080, 16'hFF81, 16'h0010, 16'h0005, 16'hFFF0, 16'h0100, 16'hFF00}
  };
  localparam logic [1:0] T_PMODE [NB] = '{2'd1, 2'd2, 2'd0, 2'd1, 2'd2, 2'd0};

  function automatic int rsat(int v, int sh);
    int r;
    r = (v + (1 << (sh - 1))) >>> sh;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // R4 kernel
  function automatic int kern(int k, int a, int b, int c, int d);
    case (k)
      0: return 29*a + 74*b + 84*c + 55*d;
      1: return 55*a + 74*b - 29*c - 84*d;
      2: return 74*a - 74*c + 74*d;
      default: return 84*a - 74*b + 55*c - 29*d;
    endcase
  endfunction

  task automatic model();
    int t [4][4];
    int r, s;
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 4; k++)
        t[k][c] = rsat(kern(k, m_c[0][c], m_c[1][c], m_c[2][c], m_c[3][c]), 7);   // R5
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 4; k++) begin
        r = rsat(kern(k, t[i][0], t[i][1], t[i][2], t[i][3]), 12);               // R6
        s = (r + m_p[i][k]) & 32'hFFFF;                                           // R7
        if (s >= 32768) s = s - 65536;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        m_o[i][k] = s;
      end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_block(bit bp, bit junk);
    logic [31:0] hold, exp;
    model();
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      check("R1 in_ready while filling", {31'd0, in_ready}, 32'd1);
      in_valid = 1'b1;
      for (int c = 0; c < 4; c++) begin
        in_coef[c*16 +: 16] = m_c[r][c][15:0];
        in_pred[c*8 +: 8]   = m_p[r][c][7:0];
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = junk;
    in_coef  = {$urandom, $urandom};
    in_pred  = $urandom;
    check("R2 gap cycle", {30'd0, in_ready, out_valid}, 32'd0);
    @(negedge clk);
    check("R2 first row valid", {31'd0, out_valid}, 32'd1);
    for (int r = 0; r < 4; r++) begin
      if (bp) begin
        out_ready = 1'b0;
        hold = out_pix;
        @(negedge clk);
        @(negedge clk);
        check("R3 hold under stall", {out_valid, out_pix[30:0]}, {1'b1, hold[30:0]});
      end
      for (int c = 0; c < 4; c++) exp[c*8 +: 8] = m_o[r][c][7:0];
      if (junk) check("R8 R3 R4 R5 R6 R7 row with busy input", out_pix, exp);
      else      check("R3 R4 R5 R6 R7 row", out_pix, exp);
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    check("R8 reopen", {30'd0, in_ready, out_valid}, 32'd2);
    out_ready = 1'b0;
    in_valid  = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R2 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_coef = '0; in_pred = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {30'd0, in_ready, out_valid}, 32'd2);
    rst_n = 1'b1;

    for (int b = 0; b < NB; b++) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) begin
          m_c[r][c] = int'($signed(T_COEF[b][r*4 + c]));
          case (T_PMODE[b])
            2'd0: m_p[r][c] = 0;
            2'd1: m_p[r][c] = 255;
            default: m_p[r][c] = (r*4 + c)*16 + 7;
          endcase
        end
      run_block(b[0], b == 3);
    end

    for (int n = 0; n < NRAND; n++) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) begin
          logic [15:0] v;
          v = $urandom;
          if (n % 3 == 0) m_c[r][c] = int'($signed(v));
          else if (n % 3 == 1) m_c[r][c] = int'($signed(v)) >>> 6;
          else m_c[r][c] = (v[0]) ? 32767 : -32768;
          m_p[r][c] = ($urandom % 4 == 0) ? (($urandom % 2) * 255) : int'($urandom % 256);
        end
      run_block(n % 4 == 1, n % 5 == 2);
    end

    // directed: reset in the middle of a fill discards the partial tile
    @(negedge clk);
    in_valid = 1'b1; in_coef = 64'h7FFF_7FFF_7FFF_7FFF; in_pred = '1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid fill", {30'd0, in_ready, out_valid}, 32'd2);
    rst_n = 1'b1;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        m_c[r][c] = (r == c) ? 1000 : -200;
        m_p[r][c] = 128;
      end
    run_block(1'b0, 1'b1);

    finish_run();
  end
endmodule